// File: doc/BRIEF.md
# Keyed Watchdog Timer

This block is a watchdog timer for a system-on-chip. It has an up-counter that moves forward on pulses of a slow tick (a clock enable at roughly 32 kHz that runs in the fast bus clock domain). When the counter passes all ones while the timer is armed, the block drives a reset pulse toward the system reset logic. Software keeps the timer from expiring by writing the trigger register now and then. Each write must carry a value that differs from the previous trigger write, and such a write loads the counter again from the load register. Because the counter counts upward, a longer timeout needs a smaller load value.

Software cannot start or stop the timer with a plain bit write. It must write two key words, one after the other, to the key register. Writes to the control, load, trigger and key registers are posted. Each one waits a fixed number of slow ticks before it takes effect. During that wait a pending bit for that register is visible in the status register. The control register can turn on a power-of-two prescaler between the tick and the counter. The revision and interface-gating registers are fixed or passive, and neither one affects counting.

Top module: `keyed_wdt`

## Requirements
- R1: After reset the counter, load, control and trigger-history registers are zero, the timer is stopped, the status register reads 0, `wdtReset` is low, and address 0 returns the revision code (default 0x31) in bits 7:0.
- R2: A write to control (address 3), load (5), trigger (6) or key (7) sets status bit 0, 2, 3 or 4 respectively. The bit stays set, and the register's committed value is unchanged, until SYNC_TICKS tick pulses have passed. A second write to the same register while it is pending replaces the first value and restarts the wait.
- R3: A committed key write of 0x0000BBBB followed directly by a committed key write of 0x00004444 starts the timer.
- R4: A committed key write of 0x0000AAAA followed directly by a committed key write of 0x00005555 stops the timer, and the counter then holds its value.
- R5: Any other key value, or a second word that does not directly follow its first word, clears the key sequence without changing the run state.
- R6: A committed trigger write loads the counter from the load register only when its data differs from the previously committed trigger value (initially 0). A repeated value leaves the counter unchanged.
- R7: While running, the counter increments by one per advance. While stopped, it changes only on a trigger reload.
- R8: With control bit 5 set, the counter advances once per 2^N ticks, where N is control bits 4:2. With bit 5 clear, it advances on every tick.
- R9: When an advance finds the counter at all ones, the counter loads from the load register and `wdtReset` goes high for exactly RST_CYCLES clock cycles.
- R10: Bit 0 of the interface-gating register (address 1) is written directly and reads back, and it has no effect on the counting rate.
- R11: Reads return the committed control value (address 3), the counter (4), the committed load value (5) and the last trigger word written (6).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle pulse at the slow functional rate |
| wrEn | input | 1 | Register write strobe |
| addr | input | 3 | Register word address |
| wrData | input | DATA_W | Write data |
| rdData | output | DATA_W | Read data, combinational from `addr` |
| wdtReset | output | 1 | Watchdog expiry reset pulse |

## Verification
The checker relies on a few conditions at the inputs. `tick` is a single-cycle pulse. `rstN` is held low for several clocks before any bus activity. The timer never expires twice within one reset pulse, which holds because RST_CYCLES is much shorter than a full count window. The bench drives a tick every fourth clock and keeps the load values far enough from all ones that a second overflow cannot occur inside a pulse. Before it writes a key register again, it polls the status register until the previous posted write has cleared, so each key word commits on its own.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  typedef enum logic [2:0] {
    A_REV    = 3'd0,
    A_SYSCFG = 3'd1,
    A_STATUS = 3'd2,
    A_CTRL   = 3'd3,
    A_COUNT  = 3'd4,
    A_LOAD   = 3'd5,
    A_TRIG   = 3'd6,
    A_KEYS   = 3'd7
  } regAddr_e;

  localparam int NUM_CH  = 4;
  localparam int CH_CTRL = 0;
  localparam int CH_LOAD = 1;
  localparam int CH_TRIG = 2;
  localparam int CH_KEYS = 3;

  localparam int CTRL_W  = 6;

  localparam logic [31:0] KEY_ARM_A = 32'h0000_BBBB;
  localparam logic [31:0] KEY_ARM_B = 32'h0000_4444;
  localparam logic [31:0] KEY_DIS_A = 32'h0000_AAAA;
  localparam logic [31:0] KEY_DIS_B = 32'h0000_5555;

  typedef enum logic [1:0] {
    K_IDLE = 2'd0,
    K_ARM  = 2'd1,
    K_DIS  = 2'd2
  } keyStage_e;

  typedef struct packed {
    logic ctrlCommit;
    logic loadCommit;
    logic reload;
    logic runSet;
    logic runClr;
  } dpStrobe_t;

  function automatic logic [2:0] chAddr(int ch);
    case (ch)
      CH_CTRL: chAddr = A_CTRL;
      CH_LOAD: chAddr = A_LOAD;
      CH_TRIG: chAddr = A_TRIG;
      default: chAddr = A_KEYS;
    endcase
  endfunction

endpackage

// File: rtl/wdt_ctrl.sv
module wdt_ctrl
  import wdt_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int COUNT_W    = 32,
  parameter int SYNC_TICKS = 2,
  parameter logic [7:0] REV_CODE = 8'h31
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                tick,
  input  logic                wrEn,
  input  logic [2:0]          addr,
  input  logic [DATA_W-1:0]   wrData,
  output logic [DATA_W-1:0]   rdData,
  output dpStrobe_t           strb,
  output logic [CTRL_W-1:0]   ctrlShadow,
  output logic [COUNT_W-1:0]  loadShadow,
  output logic [NUM_CH-1:0]   pendVec,
  input  logic [COUNT_W-1:0]  dpCount,
  input  logic [COUNT_W-1:0]  dpLoad,
  input  logic [CTRL_W-1:0]   dpCtrl
);

  localparam int SC_W = $clog2(SYNC_TICKS + 1);

  logic [NUM_CH-1:0] commit;

  // one posted-write channel per tracked register
  for (genvar g = 0; g < NUM_CH; g++) begin : gCh
    logic [DATA_W-1:0] shadowR;
    logic [SC_W-1:0]   left;
    logic              hit;
    assign hit = wrEn && (addr == chAddr(g));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        shadowR    <= '0;
        pendVec[g] <= 1'b0;
        left       <= '0;
      end else if (hit) begin
        shadowR    <= wrData;
        pendVec[g] <= 1'b1;
        left       <= SC_W'(SYNC_TICKS);
      end else if (tick && pendVec[g]) begin
        if (left == SC_W'(1)) pendVec[g] <= 1'b0;
        left <= left - SC_W'(1);
      end
    end

    assign commit[g] = tick && pendVec[g] && !hit && (left == SC_W'(1));
  end

  logic [DATA_W-1:0] keysVal, trigVal;
  assign keysVal    = gCh[CH_KEYS].shadowR;
  assign trigVal    = gCh[CH_TRIG].shadowR;
  assign ctrlShadow = gCh[CH_CTRL].shadowR[CTRL_W-1:0];
  assign loadShadow = gCh[CH_LOAD].shadowR[COUNT_W-1:0];

  // key sequence
  keyStage_e stage;
  logic      isArmA, isArmB, isDisA, isDisB;
  assign isArmA = (keysVal == DATA_W'(KEY_ARM_A));
  assign isArmB = (keysVal == DATA_W'(KEY_ARM_B));
  assign isDisA = (keysVal == DATA_W'(KEY_DIS_A));
  assign isDisB = (keysVal == DATA_W'(KEY_DIS_B));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stage <= K_IDLE;
    end else if (commit[CH_KEYS]) begin
      if (isArmA)      stage <= K_ARM;
      else if (isDisA) stage <= K_DIS;
      else             stage <= K_IDLE;
    end
  end

  // trigger history
  logic [DATA_W-1:0] lastTrig;
  always_ff @(posedge clk) begin
    if (!rstN)                 lastTrig <= '0;
    else if (commit[CH_TRIG])  lastTrig <= trigVal;
  end

  // interface gating bit: direct, unposted, passive
  logic sysCfg;
  always_ff @(posedge clk) begin
    if (!rstN)                          sysCfg <= 1'b0;
    else if (wrEn && addr == A_SYSCFG)  sysCfg <= wrData[0];
  end

  always_comb begin
    strb            = '0;
    strb.ctrlCommit = commit[CH_CTRL];
    strb.loadCommit = commit[CH_LOAD];
    strb.reload     = commit[CH_TRIG] && (trigVal != lastTrig);
    strb.runSet     = commit[CH_KEYS] && (stage == K_ARM) && isArmB;
    strb.runClr     = commit[CH_KEYS] && (stage == K_DIS) && isDisB;
  end

  always_comb begin
    rdData = '0;
    case (addr)
      A_REV:    rdData[7:0] = REV_CODE;
      A_SYSCFG: rdData[0]   = sysCfg;
      A_STATUS: begin
        rdData[0] = pendVec[CH_CTRL];
        rdData[2] = pendVec[CH_LOAD];
        rdData[3] = pendVec[CH_TRIG];
        rdData[4] = pendVec[CH_KEYS];
      end
      A_CTRL:   rdData[CTRL_W-1:0]  = dpCtrl;
      A_COUNT:  rdData[COUNT_W-1:0] = dpCount;
      A_LOAD:   rdData[COUNT_W-1:0] = dpLoad;
      A_TRIG:   rdData = trigVal;
      default:  rdData = keysVal;
    endcase
  end

endmodule

// File: rtl/wdt_datapath.sv
module wdt_datapath
  import wdt_pkg::*;
#(
  parameter int COUNT_W    = 32,
  parameter int RST_CYCLES = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               tick,
  input  dpStrobe_t          strb,
  input  logic [CTRL_W-1:0]  ctrlShadow,
  input  logic [COUNT_W-1:0] loadShadow,
  output logic [COUNT_W-1:0] count,
  output logic [COUNT_W-1:0] loadReg,
  output logic [CTRL_W-1:0]  ctrlReg,
  output logic               running,
  output logic               wdtReset
);

  localparam int EXP_W = 3;
  localparam int PRE_W = (1 << EXP_W) - 1;
  localparam int RW    = $clog2(RST_CYCLES + 1);

  logic              preEn;
  logic [EXP_W-1:0]  preExp;
  logic [PRE_W-1:0]  preCnt, preLimit;
  logic              advance, atTop;
  logic [COUNT_W-1:0] reloadVal;
  logic [RW-1:0]     rstLeft;

  assign preEn     = ctrlReg[5];
  assign preExp    = ctrlReg[4:2];
  assign preLimit  = ~({PRE_W{1'b1}} << preExp);
  assign advance   = tick && running && (!preEn || preCnt == preLimit);
  assign atTop     = (count == {COUNT_W{1'b1}});
  assign reloadVal = strb.loadCommit ? loadShadow : loadReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlReg <= '0;
      loadReg <= '0;
      running <= 1'b0;
    end else begin
      if (strb.ctrlCommit) ctrlReg <= ctrlShadow;
      if (strb.loadCommit) loadReg <= loadShadow;
      if (strb.runSet)      running <= 1'b1;
      else if (strb.runClr) running <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                             preCnt <= '0;
    else if (strb.reload || strb.ctrlCommit) preCnt <= '0;
    else if (tick && running)              preCnt <= advance ? '0 : preCnt + PRE_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rstN)            count <= '0;
    else if (strb.reload) count <= reloadVal;
    else if (advance)     count <= atTop ? loadReg : count + COUNT_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rstN)                                rstLeft <= '0;
    else if (advance && atTop && !strb.reload) rstLeft <= RW'(RST_CYCLES);
    else if (rstLeft != '0)                   rstLeft <= rstLeft - RW'(1);
  end

  assign wdtReset = (rstLeft != '0);

endmodule

// File: rtl/keyed_wdt.sv
module keyed_wdt
  import wdt_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int COUNT_W    = 32,
  parameter int SYNC_TICKS = 2,
  parameter int RST_CYCLES = 16,
  parameter logic [7:0] REV_CODE = 8'h31
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick,
  input  logic              wrEn,
  input  logic [2:0]        addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              wdtReset
);

  dpStrobe_t          strb;
  logic [CTRL_W-1:0]  ctrlShadow, dpCtrl;
  logic [COUNT_W-1:0] loadShadow, dpCount, dpLoad;
  logic [NUM_CH-1:0]  ctlPend;
  logic               dpRunning;

  wdt_ctrl #(
    .DATA_W(DATA_W), .COUNT_W(COUNT_W),
    .SYNC_TICKS(SYNC_TICKS), .REV_CODE(REV_CODE)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .tick(tick), .wrEn(wrEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .strb(strb),
    .ctrlShadow(ctrlShadow), .loadShadow(loadShadow), .pendVec(ctlPend),
    .dpCount(dpCount), .dpLoad(dpLoad), .dpCtrl(dpCtrl)
  );

  wdt_datapath #(
    .COUNT_W(COUNT_W), .RST_CYCLES(RST_CYCLES)
  ) uDp (
    .clk(clk), .rstN(rstN), .tick(tick), .strb(strb),
    .ctrlShadow(ctrlShadow), .loadShadow(loadShadow),
    .count(dpCount), .loadReg(dpLoad), .ctrlReg(dpCtrl),
    .running(dpRunning), .wdtReset(wdtReset)
  );

endmodule

// File: rtl/wdt_checker.sv
module wdt_checker
  import wdt_pkg::*;
#(
  parameter int COUNT_W    = 32,
  parameter int RST_CYCLES = 16
) (
  input logic               clk,
  input logic               rstN,
  input logic               wrEn,
  input logic [2:0]         addr,
  input logic               wdtReset,
  input logic [COUNT_W-1:0] dpCount,
  input logic               dpRunning,
  input logic [NUM_CH-1:0]  ctlPend,
  input logic               reloadStb,
  input logic               runSetStb,
  input logic               runClrStb
);

  localparam int HW = $clog2(RST_CYCLES + 2) + 1;
  logic [HW-1:0] hiCnt;

  always_ff @(posedge clk) begin
    if (!rstN)        hiCnt <= '0;
    else if (wdtReset) hiCnt <= hiCnt + HW'(1);
    else              hiCnt <= '0;
  end

  // R7
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(dpRunning) && !$past(reloadStb)) |-> $stable(dpCount));

  // R9
  ovf_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(wdtReset) |-> ($past(dpCount) == {COUNT_W{1'b1}}));

  // R9
  pulse_width_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(wdtReset) |-> (hiCnt == HW'(RST_CYCLES)));

  // R2
  pend_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == A_LOAD) |=> ctlPend[CH_LOAD]);

  // R3
  run_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dpRunning) |-> $past(runSetStb));

  // R4
  run_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(dpRunning) |-> $past(runClrStb));

endmodule

bind keyed_wdt wdt_checker #(.COUNT_W(COUNT_W), .RST_CYCLES(RST_CYCLES)) uChk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wdtReset(wdtReset),
  .dpCount(dpCount), .dpRunning(dpRunning), .ctlPend(ctlPend),
  .reloadStb(strb.reload), .runSetStb(strb.runSet), .runClrStb(strb.runClr)
);

// File: tb/sim_keyed_wdt.sv
`timescale 1ns/1ps
module sim_keyed_wdt;

  localparam int RST_CYCLES = 16;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tick = 1'b0;
  logic        wrEn = 1'b0;
  logic [2:0]  addr = 3'd0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic        wdtReset;

  int checks = 0;
  int fails  = 0;

  logic [31:0] expQ[$];
  string       tagQ[$];
  logic        sampleReq = 1'b0;

  keyed_wdt u0 (
    .clk(clk), .rstN(rstN), .tick(tick), .wrEn(wrEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .wdtReset(wdtReset)
  );

  always #10 clk = ~clk;

  int tdiv = 0;
  always @(posedge clk) begin
    tdiv <= (tdiv == 3) ? 0 : tdiv + 1;
    tick <= #1 (tdiv == 3);
  end

  // scoreboard monitor
  always @(negedge clk) begin
    if (sampleReq && expQ.size() > 0) begin
      logic [31:0] e;
      string t;
      e = expQ.pop_front();
      t = tagQ.pop_front();
      checks++;
      if (rdData !== e) begin
        fails++;
        $display("FAIL %s: got 0x%08h expected 0x%08h", t, rdData, e);
      end
    end
  end

  task automatic finishRun();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(200000 * 20);
    checks++;
    fails++;
    $display("FAIL watchdog: run hung, got timeout expected completion");
    finishRun();
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    wrEn = 1'b1; addr = a; wrData = d;
    @(posedge clk); #1;
    wrEn = 1'b0;
  endtask

  task automatic rdExp(input logic [2:0] a, input logic [31:0] e, input string t);
    @(posedge clk); #1;
    addr = a;
    expQ.push_back(e);
    tagQ.push_back(t);
    sampleReq = 1'b1;
    @(posedge clk); #1;
    sampleReq = 1'b0;
  endtask

  task automatic peek(input logic [2:0] a, output logic [31:0] v);
    @(posedge clk); #1;
    addr = a;
    @(negedge clk);
    v = rdData;
  endtask

  task automatic chk(input bit ok, input string t, input logic [31:0] act, input logic [31:0] e);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", t, act, e);
    end
  endtask

  task automatic waitIdle();
    for (int i = 0; i < 200; i++) begin
      logic [31:0] s;
      peek(3'd2, s);
      if (s == 0) break;
    end
  endtask

  task automatic wrIdle(input logic [2:0] a, input logic [31:0] d);
    wr(a, d);
    waitIdle();
  endtask

  task automatic rate(input int clks, input string t);
    logic [31:0] a0, a1;
    peek(3'd4, a0);
    repeat (clks) @(posedge clk);
    peek(3'd4, a1);
    chk((a1 - a0) >= 9 && (a1 - a0) <= 11, t, a1 - a0, 32'd10);
  endtask

  initial begin
    logic [31:0] v0, v1;
    int width;
    repeat (6) @(posedge clk);
    #1 rstN = 1'b1;

    // R1 reset state
    rdExp(3'd2, 32'h0, "R1 status");
    rdExp(3'd4, 32'h0, "R1 count");
    rdExp(3'd3, 32'h0, "R1 ctrl");
    rdExp(3'd0, 32'h31, "R1 revision");
    chk(wdtReset == 1'b0, "R1 reset output", {31'd0, wdtReset}, 32'd0);

    // R2 posted load write
    wr(3'd5, 32'h1000);
    rdExp(3'd2, 32'h4, "R2 load pending bit");
    rdExp(3'd5, 32'h0, "R2 load not yet committed");
    waitIdle();
    rdExp(3'd5, 32'h1000, "R2 load committed");
    // R2 overwrite while pending
    wr(3'd5, 32'h2000);
    wr(3'd5, 32'h3000);
    waitIdle();
    rdExp(3'd5, 32'h3000, "R2 last pending write wins");
    wr(3'd3, 32'h0);
    rdExp(3'd2, 32'h1, "R2 ctrl pending bit");
    waitIdle();
    wr(3'd6, 32'h1234);
    rdExp(3'd2, 32'h8, "R2 trigger pending bit");
    waitIdle();

    // R6 reload on new trigger value (stopped timer)
    rdExp(3'd4, 32'h3000, "R6 reload from load");
    rdExp(3'd6, 32'h1234, "R11 trigger readback");
    wrIdle(3'd5, 32'h4000);
    wrIdle(3'd6, 32'h1234);
    rdExp(3'd4, 32'h3000, "R6 repeated trigger ignored");
    wrIdle(3'd6, 32'hEDCB);
    rdExp(3'd4, 32'h4000, "R6 changed trigger reloads");
    repeat (100) @(posedge clk);
    rdExp(3'd4, 32'h4000, "R7 stopped counter holds");

    // R5 broken start sequences
    wr(3'd7, 32'hBBBB);
    rdExp(3'd2, 32'h10, "R2 key pending bit");
    waitIdle();
    wrIdle(3'd7, 32'h1111);
    wrIdle(3'd7, 32'h4444);
    repeat (60) @(posedge clk);
    rdExp(3'd4, 32'h4000, "R5 interrupted start ignored");
    wrIdle(3'd7, 32'h4444);
    repeat (40) @(posedge clk);
    rdExp(3'd4, 32'h4000, "R5 lone second word ignored");

    // R3 start, R7 rate
    wrIdle(3'd7, 32'hBBBB);
    wrIdle(3'd7, 32'h4444);
    rate(40, "R3 R7 running one per tick");

    // R5 broken stop leaves it running
    wrIdle(3'd7, 32'hAAAA);
    wrIdle(3'd7, 32'h1111);
    wrIdle(3'd7, 32'h5555);
    rate(40, "R5 interrupted stop ignored");

    // R8 prescaler 2^2
    wrIdle(3'd3, 32'h28);
    rdExp(3'd3, 32'h28, "R11 ctrl readback");
    rate(160, "R8 prescaled rate");

    // R10 gating bit
    wr(3'd1, 32'h1);
    rdExp(3'd1, 32'h1, "R10 gating readback");
    wrIdle(3'd3, 32'h0);
    rate(40, "R10 gating bit leaves rate");

    // R4 stop
    wrIdle(3'd7, 32'hAAAA);
    wrIdle(3'd7, 32'h5555);
    peek(3'd4, v0);
    repeat (60) @(posedge clk);
    peek(3'd4, v1);
    chk(v0 == v1, "R4 stopped counter frozen", v1, v0);

    // R9 overflow
    wrIdle(3'd5, 32'hFFFF_FFF8);
    wrIdle(3'd6, 32'h5A5A);
    rdExp(3'd4, 32'hFFFF_FFF8, "R9 near-top load");
    wrIdle(3'd7, 32'hBBBB);
    wrIdle(3'd7, 32'h4444);
    for (int i = 0; i < 1000; i++) begin
      @(negedge clk);
      if (wdtReset) break;
    end
    width = 0;
    while (wdtReset && width < 100) begin
      width++;
      @(negedge clk);
    end
    chk(width == RST_CYCLES, "R9 reset pulse width", width, RST_CYCLES);
    peek(3'd4, v0);
    chk(v0 >= 32'hFFFF_FFF8, "R9 counter reloaded after overflow", v0, 32'hFFFF_FFF8);
    wrIdle(3'd7, 32'hAAAA);
    wrIdle(3'd7, 32'h5555);

    repeat (4) @(posedge clk);
    finishRun();
  end

endmodule